// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a bit-timing stage that delivers one sampled bus level per strobe. It waits on an idle bus for the first dominant level, treats it as start of frame, drops stuff bits, and splits the remaining bit stream into the fields of a standard or extended data or remote frame. It produces the base, extended and combined identifiers, the frame-type flags, the length code, each data byte with a one-cycle strobe and its byte number, the received CRC sequence, a CRC mismatch flag, the acknowledge status and a form warning.

The field layout after the identifier-extension bit is not fixed. It depends on the frame type and on the length code, so the block computes the positions of the data, CRC, delimiter, acknowledge and end-of-frame fields from values it has already received. A single-cycle done pulse marks the last end-of-frame bit. All decoded fields then hold their values until the next start of frame clears them.

Top module: `can_fp_top`

## Requirements
- R1: While idle, a strobed recessive bit (bit_in = 1) is ignored and leaves every output unchanged; a strobed dominant bit (bit_in = 0) is taken as start of frame, frame bit 0.
- R2: Once five equal raw bits in a row have been received, a following raw bit of the opposite level is dropped and does not advance the frame bit index. This rule covers raw bits from start of frame up to and including the raw bit that arrives when the CRC delimiter is next expected, so a stuff bit after the last CRC bit is dropped. The ACK slot, ACK delimiter and end-of-frame bits are never dropped.
- R3: Frame bits 1 to 11 form base_id, MSB first. Bit 13 is the extension flag: 0 gives is_ext = 0 (standard), 1 gives is_ext = 1 (extended).
- R4: In a standard frame, bit 12 gives is_remote (1 = remote), bits 15 to 18 give dlc MSB first, and the data field starts at bit 19.
- R5: In an extended frame, bits 14 to 31 give ext_id MSB first, bit 32 gives is_remote, bits 35 to 38 give dlc, and data starts at bit 39. full_id equals base_id shifted left by 18 ORed with ext_id. In a standard frame, ext_id is 0.
- R6: Each data byte is assembled MSB first and shown on data_byte with a one-cycle data_valid and data_idx counting from 0. The number of bytes is the dlc value capped at 8, and is zero for a remote frame. dlc itself reports the received 4-bit code unchanged.
- R7: The 15 bits after the data field (after the length code for a remote frame) appear on crc_rx, MSB first.
- R8: A CRC-15 with polynomial 0x4599 and initial value 0 is computed over the destuffed bits from start of frame through the last data bit. crc_err is set when it differs from crc_rx and is clear when they match.
- R9: ack_ok is 1 when the ACK slot bit is dominant and 0 when it is recessive.
- R10: form_warn is set when the CRC delimiter, the ACK delimiter or any of the 7 end-of-frame bits is dominant.
- R11: frame_done is high for exactly one cycle, on the clock edge that takes in the seventh end-of-frame bit. The decoded outputs hold until the next start of frame, whose clock edge clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | Strobe: bit_in holds a sampled bus level |
| bit_in | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| frame_done | output | 1 | One-cycle pulse on the last end-of-frame bit |
| is_ext | output | 1 | Extended frame |
| is_remote | output | 1 | Remote frame |
| base_id | output | 11 | Base identifier |
| ext_id | output | 18 | Extended identifier |
| full_id | output | 29 | Combined identifier |
| dlc | output | 4 | Received length code |
| data_valid | output | 1 | Strobe for data_byte |
| data_idx | output | 3 | Byte number of data_byte |
| data_byte | output | 8 | Received data byte |
| crc_rx | output | 15 | Received CRC sequence |
| crc_err | output | 1 | Computed CRC differs from crc_rx |
| ack_ok | output | 1 | ACK slot was dominant |
| form_warn | output | 1 | A fixed recessive bit was dominant |

## Verification
The checker watches several properties on every cycle. The done pulse lasts one cycle. A dropped stuff bit leaves the frame index unchanged. Data strobes occur only for byte numbers below the capped length code and never in a remote frame. The CRC flag rises only in response to a strobed bit, and a standard frame reports a zero extended identifier. Some behaviour shows only in the bench's frames: whether the destuffing windows line up with a given bit pattern, whether the field positions are right after the length code moves them, and whether CRC, ACK and form results come out right. The bench covers these with directed frames (all-zero payloads, length codes above 8, remote frames, corrupted CRC, missing ACK, dominant end-of-frame bit) and with random frames.

// File: rtl/can_fp_pkg.sv
package can_fp_pkg;
   localparam int BASE_W = 11;
   localparam int EXT_W = 18;
   localparam int FULL_W = BASE_W + EXT_W;
   localparam int DLC_W = 4;
   localparam int CRC_W = 15;
   localparam int BYTE_W = 8;
   localparam int PROTO_MAX_BYTES = 8;
   localparam int BIDX_W = $clog2(PROTO_MAX_BYTES);
   localparam int BPOS_W = $clog2(BYTE_W);
   localparam int IDX_W = 8;

   typedef logic [IDX_W-1:0] fidx_t;

   // frame bit positions that do not depend on the length code
   localparam fidx_t P_BASE_FIRST = fidx_t'(1);
   localparam fidx_t P_BASE_LAST = fidx_t'(BASE_W);
   localparam fidx_t P_RTR_SRR = fidx_t'(BASE_W + 1);
   localparam fidx_t P_IDE = fidx_t'(BASE_W + 2);
   localparam fidx_t P_STD_DLC = fidx_t'(BASE_W + 4);
   localparam fidx_t P_EXT_FIRST = fidx_t'(BASE_W + 3);
   localparam fidx_t P_EXT_LAST = fidx_t'(BASE_W + 2 + EXT_W);
   localparam fidx_t P_EXT_RTR = fidx_t'(BASE_W + 3 + EXT_W);
   localparam fidx_t P_EXT_DLC = fidx_t'(BASE_W + 6 + EXT_W);
endpackage

// File: rtl/can_fp_destuff.sv
module can_fp_destuff #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   input  logic restart,
   input  logic check_en,
   output logic stuff_hit
);
   localparam int CNT_W = $clog2(RUN_LEN + 2);
   localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] RUN_SAT = CNT_W'(RUN_LEN + 1);

   logic [CNT_W-1:0] run;
   logic             last;

   assign stuff_hit = in_valid && !restart && check_en &&
                      (run == RUN_MAX) && (in_bit != last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= '0;
         last <= 1'b1;
      end else if (in_valid) begin
         last <= in_bit;
         if (restart || in_bit != last)
            run <= CNT_W'(1);
         else if (run != RUN_SAT)
            run <= run + CNT_W'(1);
      end
   end
endmodule

// File: rtl/can_fp_crc.sv
module can_fp_crc #(
   parameter int W = 15,
   parameter logic [W-1:0] POLY = 15'h4599,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic         fb;

   assign base = clear ? INIT : crc;
   assign fb = din ^ base[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[i] = fb & POLY[i];
      end else begin : g_mid
         assign nxt[i] = base[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= INIT;
      else if (shift)
         crc <= nxt;
      else if (clear)
         crc <= INIT;
   end
endmodule

// File: rtl/can_fp_layout.sv
module can_fp_layout
   import can_fp_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter int EOF_LEN = 7
) (
   input  logic             is_ext,
   input  logic             is_remote,
   input  logic [DLC_W-1:0] dlc,
   output fidx_t            data_start,
   output fidx_t            crc_start,
   output fidx_t            crc_last,
   output fidx_t            delim_pos,
   output fidx_t            ack_pos,
   output fidx_t            ackd_pos,
   output fidx_t            eof_first,
   output fidx_t            eof_last
);
   localparam logic [DLC_W-1:0] CAP = DLC_W'(MAX_BYTES);

   logic [DLC_W-1:0] nbytes;

   assign nbytes = is_remote ? '0 : ((dlc > CAP) ? CAP : dlc);
   assign data_start = (is_ext ? P_EXT_DLC : P_STD_DLC) + fidx_t'(DLC_W);
   assign crc_start = data_start + fidx_t'(nbytes) * fidx_t'(BYTE_W);
   assign crc_last = crc_start + fidx_t'(CRC_W - 1);
   assign delim_pos = crc_start + fidx_t'(CRC_W);
   assign ack_pos = delim_pos + fidx_t'(1);
   assign ackd_pos = delim_pos + fidx_t'(2);
   assign eof_first = delim_pos + fidx_t'(3);
   assign eof_last = eof_first + fidx_t'(EOF_LEN - 1);
endmodule

// File: rtl/can_fp_top.sv
module can_fp_top
   import can_fp_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599,
   parameter logic [CRC_W-1:0] CRC_INIT = '0,
   parameter int STUFF_RUN = 5,
   parameter int EOF_LEN = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_in,
   output logic              frame_done,
   output logic              is_ext,
   output logic              is_remote,
   output logic [BASE_W-1:0] base_id,
   output logic [EXT_W-1:0]  ext_id,
   output logic [FULL_W-1:0] full_id,
   output logic [DLC_W-1:0]  dlc,
   output logic              data_valid,
   output logic [BIDX_W-1:0] data_idx,
   output logic [BYTE_W-1:0] data_byte,
   output logic [CRC_W-1:0]  crc_rx,
   output logic              crc_err,
   output logic              ack_ok,
   output logic              form_warn
);
   if (MAX_BYTES < 1 || MAX_BYTES > PROTO_MAX_BYTES) begin : g_bad_bytes
      $error("can_fp_top: MAX_BYTES out of range");
   end
   if (STUFF_RUN < 2) begin : g_bad_run
      $error("can_fp_top: STUFF_RUN too small");
   end
   if (EOF_LEN < 1 || EOF_LEN > 16) begin : g_bad_eof
      $error("can_fp_top: EOF_LEN out of range");
   end

   logic              in_frame;
   fidx_t             idx;
   logic              rtr_srr;
   logic [BYTE_W-1:0] byte_sr;
   logic [BPOS_W-1:0] bit_cnt;
   logic [BIDX_W-1:0] byte_cnt;
   logic              stuff_hit;
   logic              start;
   logic              acc;
   logic              in_data;
   logic [CRC_W-1:0]  crc_calc;
   fidx_t             data_start, crc_start, crc_last, delim_pos;
   fidx_t             ack_pos, ackd_pos, eof_first, eof_last;

   assign start = bit_valid && !in_frame && !bit_in;
   assign acc = bit_valid && in_frame && !stuff_hit;
   assign in_data = (idx >= data_start) && (idx < crc_start);
   assign full_id = {base_id, ext_id};

   can_fp_destuff #(.RUN_LEN(STUFF_RUN)) u_ds (
      .clk(clk), .rst_n(rst_n), .in_valid(bit_valid), .in_bit(bit_in),
      .restart(!in_frame), .check_en(idx <= delim_pos), .stuff_hit(stuff_hit)
   );

   can_fp_layout #(.MAX_BYTES(MAX_BYTES), .EOF_LEN(EOF_LEN)) u_lay (
      .is_ext(is_ext), .is_remote(is_remote), .dlc(dlc),
      .data_start(data_start), .crc_start(crc_start), .crc_last(crc_last),
      .delim_pos(delim_pos), .ack_pos(ack_pos), .ackd_pos(ackd_pos),
      .eof_first(eof_first), .eof_last(eof_last)
   );

   can_fp_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst_n(rst_n), .clear(start),
      .shift(start || (acc && idx < crc_start)), .din(bit_in), .crc(crc_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0; idx <= '0; rtr_srr <= 1'b0;
         frame_done <= 1'b0; is_ext <= 1'b0; is_remote <= 1'b0;
         base_id <= '0; ext_id <= '0; dlc <= '0;
         byte_sr <= '0; bit_cnt <= '0; byte_cnt <= '0;
         data_valid <= 1'b0; data_idx <= '0; data_byte <= '0;
         crc_rx <= '0; crc_err <= 1'b0; ack_ok <= 1'b0; form_warn <= 1'b0;
      end else begin
         data_valid <= 1'b0;
         frame_done <= 1'b0;
         if (start) begin
            in_frame <= 1'b1; idx <= fidx_t'(1); rtr_srr <= 1'b0;
            is_ext <= 1'b0; is_remote <= 1'b0;
            base_id <= '0; ext_id <= '0; dlc <= '0;
            byte_sr <= '0; bit_cnt <= '0; byte_cnt <= '0;
            data_idx <= '0; data_byte <= '0;
            crc_rx <= '0; crc_err <= 1'b0; ack_ok <= 1'b0; form_warn <= 1'b0;
         end else if (acc) begin
            idx <= idx + fidx_t'(1);
            if (idx >= P_BASE_FIRST && idx <= P_BASE_LAST)
               base_id <= {base_id[BASE_W-2:0], bit_in};
            if (idx == P_RTR_SRR)
               rtr_srr <= bit_in;
            if (idx == P_IDE) begin
               is_ext <= bit_in;
               if (!bit_in) is_remote <= rtr_srr;
            end
            if (is_ext) begin
               if (idx >= P_EXT_FIRST && idx <= P_EXT_LAST)
                  ext_id <= {ext_id[EXT_W-2:0], bit_in};
               if (idx == P_EXT_RTR)
                  is_remote <= bit_in;
               if (idx >= P_EXT_DLC && idx < P_EXT_DLC + fidx_t'(DLC_W))
                  dlc <= {dlc[DLC_W-2:0], bit_in};
            end else if (idx >= P_STD_DLC && idx < P_STD_DLC + fidx_t'(DLC_W)) begin
               dlc <= {dlc[DLC_W-2:0], bit_in};
            end
            if (in_data) begin
               byte_sr <= {byte_sr[BYTE_W-2:0], bit_in};
               bit_cnt <= bit_cnt + BPOS_W'(1);
               if (bit_cnt == BPOS_W'(BYTE_W - 1)) begin
                  data_valid <= 1'b1;
                  data_byte <= {byte_sr[BYTE_W-2:0], bit_in};
                  data_idx <= byte_cnt;
                  byte_cnt <= byte_cnt + BIDX_W'(1);
               end
            end
            if (idx >= crc_start && idx <= crc_last)
               crc_rx <= {crc_rx[CRC_W-2:0], bit_in};
            if (idx == crc_last)
               crc_err <= ({crc_rx[CRC_W-2:0], bit_in} != crc_calc);
            if (idx == ack_pos)
               ack_ok <= !bit_in;
            if (!bit_in && (idx == delim_pos || idx == ackd_pos ||
                            (idx >= eof_first && idx <= eof_last)))
               form_warn <= 1'b1;
            if (idx == eof_last) begin
               frame_done <= 1'b1;
               in_frame <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/can_fp_chk.sv
module can_fp_chk
   import can_fp_pkg::*;
#(
   parameter int MAX_BYTES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_valid,
   input logic              frame_done,
   input logic              data_valid,
   input logic [BIDX_W-1:0] data_idx,
   input logic [DLC_W-1:0]  dlc,
   input logic              is_remote,
   input logic              is_ext,
   input logic [EXT_W-1:0]  ext_id,
   input logic              crc_err,
   input logic              stuff_hit,
   input fidx_t             idx
);
   logic [DLC_W-1:0] cap_bytes;
   assign cap_bytes = (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R2
   stuff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_hit |=> $stable(idx));

   // R6
   data_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (!is_remote && (DLC_W'(data_idx) < cap_bytes)));

   // R6
   data_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !data_valid);

   // R8
   crc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> $past(bit_valid));

   // R5
   std_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !is_ext) |-> (ext_id == '0));
endmodule

bind can_fp_top can_fp_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .frame_done(frame_done),
   .data_valid(data_valid), .data_idx(data_idx), .dlc(dlc),
   .is_remote(is_remote), .is_ext(is_ext), .ext_id(ext_id),
   .crc_err(crc_err), .stuff_hit(stuff_hit), .idx(idx)
);

// File: tb/tb_can_fp_top.sv
module tb_can_fp_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_valid = 1'b0;
   logic bit_in = 1'b1;
   logic frame_done, is_ext, is_remote, data_valid, crc_err, ack_ok, form_warn;
   logic [10:0] base_id;
   logic [17:0] ext_id;
   logic [28:0] full_id;
   logic [3:0]  dlc;
   logic [2:0]  data_idx;
   logic [7:0]  data_byte;
   logic [14:0] crc_rx;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_fp_top dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .frame_done(frame_done), .is_ext(is_ext), .is_remote(is_remote),
      .base_id(base_id), .ext_id(ext_id), .full_id(full_id), .dlc(dlc),
      .data_valid(data_valid), .data_idx(data_idx), .data_byte(data_byte),
      .crc_rx(crc_rx), .crc_err(crc_err), .ack_ok(ack_ok), .form_warn(form_warn)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   bit fb[0:255];
   int fl;
   bit rb[0:319];
   int rl;
   int n_stuff;

   bit          e_ext, e_rtr, e_crc_err, e_ack, e_form;
   logic [10:0] e_bid;
   logic [17:0] e_eid;
   logic [3:0]  e_dlc;
   int          e_nb;
   logic [7:0]  e_data[0:7];
   logic [14:0] e_crc_rx;

   int          mon_cnt = 0;
   int          mon_done = 0;
   int          mon_order_bad = 0;
   logic [7:0]  mon_data[0:7];

   always @(negedge clk) begin
      if (rst_n && data_valid) begin
         if (int'(data_idx) != mon_cnt) mon_order_bad++;
         mon_data[data_idx] = data_byte;
         mon_cnt++;
      end
      if (rst_n && frame_done) mon_done++;
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input bit b);
      fb[fl] = b;
      fl++;
   endtask

   function automatic logic [14:0] ref_crc(input int n);
      logic [14:0] c = '0;
      for (int i = 0; i < n; i++) begin
         bit f = fb[i] ^ c[14];
         c = {c[13:0], 1'b0};
         if (f) c = c ^ 15'h4599;
      end
      return c;
   endfunction

   task automatic make_frame(input bit ext, input logic [10:0] bid,
                             input logic [17:0] eid, input bit rtr,
                             input logic [3:0] dl, input bit crc_bad,
                             input bit nack, input bit eof_dom);
      logic [14:0] c;
      int run;
      bit last;
      e_ext = ext; e_bid = bid; e_eid = ext ? eid : 18'h0; e_rtr = rtr;
      e_dlc = dl; e_crc_err = crc_bad; e_ack = !nack; e_form = eof_dom;
      e_nb = rtr ? 0 : ((dl > 8) ? 8 : int'(dl));
      fl = 0;
      push(1'b0);
      for (int i = 10; i >= 0; i--) push(bid[i]);
      if (ext) begin
         push(1'b1); push(1'b1);
         for (int i = 17; i >= 0; i--) push(eid[i]);
         push(rtr); push(1'b0); push(1'b0);
      end else begin
         push(rtr); push(1'b0); push(1'b0);
      end
      for (int i = 3; i >= 0; i--) push(dl[i]);
      for (int k = 0; k < e_nb; k++)
         for (int i = 7; i >= 0; i--) push(e_data[k][i]);
      c = ref_crc(fl);
      e_crc_rx = crc_bad ? (c ^ 15'h0001) : c;
      for (int i = 14; i >= 0; i--) push(e_crc_rx[i]);
      rl = 0; run = 0; last = 1'b1; n_stuff = 0;
      for (int i = 0; i < fl; i++) begin
         rb[rl] = fb[i]; rl++;
         if (i == 0 || fb[i] != last) run = 1; else run++;
         last = fb[i];
         if (run == 5) begin
            rb[rl] = !last; rl++; n_stuff++;
            last = !last; run = 1;
         end
      end
      rb[rl] = 1'b1; rl++;
      rb[rl] = nack; rl++;
      rb[rl] = 1'b1; rl++;
      for (int i = 0; i < 7; i++) begin
         rb[rl] = (eof_dom && i == 3) ? 1'b0 : 1'b1; rl++;
      end
   endtask

   task automatic send_bit(input bit b, input int gap);
      @(negedge clk);
      bit_valid = 1'b1; bit_in = b;
      @(negedge clk);
      bit_valid = 1'b0; bit_in = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic run_frame(input int max_gap);
      mon_cnt = 0; mon_done = 0; mon_order_bad = 0;
      for (int i = 0; i < rl; i++) begin
         send_bit(rb[i], (i == 0) ? 0 : int'($urandom % (max_gap + 1)));
         if (i == 0) begin
            // R11: fields cleared on the start-of-frame edge
            chk("R11", "cleared base_id", base_id, 0);
            chk("R11", "cleared crc/ack/form", {crc_rx, crc_err, ack_ok, form_warn}, 0);
         end
      end
      repeat (3) @(negedge clk);
      chk("R3", "base_id", base_id, e_bid);
      chk("R3", "is_ext", is_ext, e_ext);
      chk(e_ext ? "R5" : "R4", "is_remote", is_remote, e_rtr);
      chk(e_ext ? "R5" : "R4", "dlc", dlc, e_dlc);
      chk("R5", "ext_id", ext_id, e_eid);
      chk("R5", "full_id", full_id, {e_bid, e_eid});
      chk("R6", "byte count", mon_cnt, e_nb);
      chk("R6", "byte order", mon_order_bad, 0);
      for (int k = 0; k < e_nb; k++) chk("R6", "data byte", mon_data[k], e_data[k]);
      chk(n_stuff > 0 ? "R2" : "R7", "crc_rx", crc_rx, e_crc_rx);
      chk("R8", "crc_err", crc_err, e_crc_err);
      chk("R9", "ack_ok", ack_ok, e_ack);
      chk("R10", "form_warn", form_warn, e_form);
      chk("R11", "done pulses", mon_done, 1);
   endtask

   task automatic fill_data(input bit zero);
      for (int k = 0; k < 8; k++) e_data[k] = zero ? 8'h00 : 8'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "reset outputs",
          {frame_done, is_ext, is_remote, base_id, ext_id, dlc, data_valid,
           crc_err, ack_ok, form_warn}, 0);

      // standard data frame, zero payload forces many stuff bits (R2)
      fill_data(1'b1);
      make_frame(1'b0, 11'h000, 18'h0, 1'b0, 4'd8, 1'b0, 1'b0, 1'b0);
      run_frame(0);

      // R1: recessive bits while idle leave outputs alone
      mon_done = 0;
      for (int i = 0; i < 6; i++) send_bit(1'b1, 1);
      chk("R1", "idle done", mon_done, 0);
      chk("R1", "idle dlc/base", {dlc, base_id}, {e_dlc, e_bid});

      // extended remote frame with a nonzero length code
      fill_data(1'b0);
      make_frame(1'b1, 11'h5A3, 18'h2B1C7, 1'b1, 4'd5, 1'b0, 1'b0, 1'b0);
      run_frame(2);

      // length code above 8 is capped
      fill_data(1'b0);
      make_frame(1'b0, 11'h1F0, 18'h0, 1'b0, 4'd15, 1'b0, 1'b0, 1'b0);
      run_frame(1);

      // corrupted CRC, missing ACK, dominant EOF bit
      fill_data(1'b0);
      make_frame(1'b1, 11'h7FF, 18'h3FFFF, 1'b0, 4'd3, 1'b1, 1'b1, 1'b1);
      run_frame(1);

      // standard data frame, no payload
      make_frame(1'b0, 11'h2AA, 18'h0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
      run_frame(0);

      for (int f = 0; f < 24; f++) begin
         fill_data(($urandom % 5) == 0);
         make_frame(1'($urandom), 11'($urandom), 18'($urandom),
                    ($urandom % 4) == 0, 4'($urandom),
                    ($urandom % 8) == 0, ($urandom % 6) == 0,
                    ($urandom % 8) == 0);
         run_frame(2);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule